// File: doc/BRIEF.md
# Watchdog and Power-On Reset Supervisor

This block produces the system reset for a processor. It holds reset from the moment power is applied. It also holds reset for as long as a digital low-supply flag is raised. After the supply has been good for a fixed stabilisation interval, reset is released. From then on, a watchdog watches the active-low chip-select line of the serial bus that the processor drives. Each falling edge of chip select counts as a kick. If no kick arrives within the selected timeout, reset is asserted again, whether the line is stuck high or stuck low.

The timeout comes from a 2-bit selection register input. Three codes pick preset intervals and the fourth turns the watchdog off. All intervals are counted in cycles of the system clock, and the counter limits are parameters. Chip select passes through a synchroniser before the edge detector. Both polarities of reset are driven, and they are always complementary.

Top module: `rst_supervisor`

## Requirements
- R1: While `porN` is low, and from its release until the supply is valid, `resetHigh` is 1 and `resetLow` is 0.
- R2: When `supplyLow` is 1 at a clock edge, reset is asserted after that edge and stays asserted while the flag stays 1.
- R3: Reset is released at the (STAB_CYCLES+1)-th consecutive clock edge at which `supplyLow` is sampled 0. A 1 at any of these edges restarts the interval.
- R4: While out of reset and with the watchdog enabled, reset asserts at the (L+1)-th edge after the watchdog count last restarted if no kick arrives, where L is the selected limit.
- R5: A falling edge of `csN` is seen three clock edges after it occurs (two synchroniser flops and one edge register) and restarts the watchdog count from zero.
- R6: `timeoutSel` encoding: 2'b00 selects WDOG_LONG, 2'b01 selects WDOG_MID, 2'b10 selects WDOG_SHORT, and 2'b11 disables the watchdog, so reset never asserts from chip-select inactivity.
- R7: `resetLow` is always the complement of `resetHigh`.
- R8: After a watchdog reset, reset is held for the same STAB_CYCLES+1 interval. On release, the watchdog count restarts from zero.
- R9: `timeoutSel` is captured only when the watchdog count restarts, either on a kick or on leaving reset. A change between those points does not alter the running timeout.
- R10: `csN` held low with no falling edge trips the watchdog exactly like `csN` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| supplyLow | input | 1 | Digital low-supply flag, synchronous to clk |
| csN | input | 1 | Chip-select line used as watchdog kick, asynchronous |
| timeoutSel | input | 2 | Watchdog timeout selection |
| resetHigh | output | 1 | System reset, active high |
| resetLow | output | 1 | System reset, active low |

## Verification
The supply flag affects reset one edge after it is sampled. A chip-select fall reaches the watchdog count three edges after the pin moves. Release comes STAB_CYCLES+1 edges after the supply is first seen good, and a watchdog trip comes L+1 edges after the last restart. The bench drives inputs on the falling clock edge. It advances a behavioural model on every rising edge with the same sampled inputs, and compares both reset outputs with the model at each falling edge. Each fault pattern is therefore checked at exactly the cycle it is due, not within a window.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_STAB = 2'd1,
    ST_RUN  = 2'd2
  } supState_t;

  typedef struct packed {
    logic stabClear;
    logic stabInc;
    logic wdogRestart;
    logic wdogRun;
  } supStrobe_t;

  localparam logic [1:0] SEL_LONG  = 2'b00;
  localparam logic [1:0] SEL_MID   = 2'b01;
  localparam logic [1:0] SEL_SHORT = 2'b10;
  localparam logic [1:0] SEL_OFF   = 2'b11;
endpackage

// File: rtl/sup_datapath.sv
module sup_datapath
  import sup_pkg::*;
#(
  parameter int STAB_CYCLES = 50_000_000,
  parameter int WDOG_LONG   = 350_000_000,
  parameter int WDOG_MID    = 150_000_000,
  parameter int WDOG_SHORT  = 50_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       csN,
  input  logic [1:0] timeoutSel,
  input  supStrobe_t strobe,
  output logic       stabDone,
  output logic       wdExpire
);
  localparam int STAB_W = $clog2(STAB_CYCLES + 1);
  localparam int WD_MAX = (WDOG_LONG > WDOG_MID)
                          ? ((WDOG_LONG > WDOG_SHORT) ? WDOG_LONG : WDOG_SHORT)
                          : ((WDOG_MID > WDOG_SHORT) ? WDOG_MID : WDOG_SHORT);
  localparam int WD_W   = $clog2(WD_MAX + 1);

  // chip-select synchroniser, reset to deselected
  logic [SYNC_STAGES-1:0] csPipe;
  logic csPrev;
  logic csFall;

  generate
    genvar gi;
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) csPipe[gi] <= 1'b1;
        else if (gi == 0) csPipe[gi] <= csN;
        else csPipe[gi] <= csPipe[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) csPrev <= 1'b1;
    else csPrev <= csPipe[SYNC_STAGES-1];
  end

  assign csFall = csPrev & ~csPipe[SYNC_STAGES-1];

  // stabilisation counter
  logic [STAB_W-1:0] stabCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) stabCnt <= '0;
    else if (strobe.stabClear) stabCnt <= '0;
    else if (strobe.stabInc) stabCnt <= stabCnt + 1'b1;
  end

  assign stabDone = (stabCnt == STAB_W'(STAB_CYCLES - 1));

  // watchdog selection and counter
  logic [1:0]      activeSel;
  logic [WD_W-1:0] wdCnt;
  logic [WD_W-1:0] limitCur;
  logic            wdEnabled;
  logic            wdRestart;

  always_comb begin
    case (activeSel)
      SEL_LONG:  limitCur = WD_W'(WDOG_LONG);
      SEL_MID:   limitCur = WD_W'(WDOG_MID);
      SEL_SHORT: limitCur = WD_W'(WDOG_SHORT);
      default:   limitCur = '0;
    endcase
  end

  assign wdEnabled = (activeSel != SEL_OFF);
  assign wdRestart = strobe.wdogRestart | (csFall & strobe.wdogRun);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      activeSel <= SEL_OFF;
      wdCnt     <= '0;
    end else if (wdRestart) begin
      activeSel <= timeoutSel;
      wdCnt     <= '0;
    end else if (strobe.wdogRun && wdEnabled && (wdCnt != limitCur)) begin
      wdCnt <= wdCnt + 1'b1;
    end
  end

  assign wdExpire = wdEnabled && (wdCnt == limitCur);

  assert_kick_restart_R5: assert property (@(posedge clk) disable iff (!porN)
    (csFall && strobe.wdogRun) |=> (wdCnt == '0));

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!porN)
    !(csFall && strobe.wdogRun) && !strobe.wdogRestart |=> $stable(activeSel));

  assert_off_never_expires_R6: assert property (@(posedge clk) disable iff (!porN)
    (activeSel == SEL_OFF) |-> !wdExpire);
endmodule

// File: rtl/sup_control.sv
module sup_control
  import sup_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       supplyLow,
  input  logic       stabDone,
  input  logic       wdExpire,
  output supStrobe_t strobe,
  output logic       resetActive
);
  supState_t state, stateNext;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_HOLD;
    else state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_HOLD: begin
        strobe.stabClear = 1'b1;
        if (!supplyLow) stateNext = ST_STAB;
      end
      ST_STAB: begin
        if (supplyLow) begin
          stateNext        = ST_HOLD;
          strobe.stabClear = 1'b1;
        end else if (stabDone) begin
          stateNext          = ST_RUN;
          strobe.wdogRestart = 1'b1;
        end else begin
          strobe.stabInc = 1'b1;
        end
      end
      ST_RUN: begin
        strobe.wdogRun = 1'b1;
        if (supplyLow) begin
          stateNext        = ST_HOLD;
          strobe.stabClear = 1'b1;
        end else if (wdExpire) begin
          stateNext        = ST_STAB;
          strobe.stabClear = 1'b1;
        end
      end
      default: begin
        stateNext        = ST_HOLD;
        strobe.stabClear = 1'b1;
      end
    endcase
  end

  assign resetActive = (state != ST_RUN);

  assert_supply_hold_R2: assert property (@(posedge clk) disable iff (!porN)
    supplyLow |=> resetActive);

  assert_release_after_stab_R3: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_RUN) && ($past(state) != ST_RUN) |-> $past(stabDone) && !$past(supplyLow));

  assert_wdog_fire_R4: assert property (@(posedge clk) disable iff (!porN)
    (state == ST_RUN) && wdExpire && !supplyLow |=> (state == ST_STAB));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import sup_pkg::*;
#(
  parameter int STAB_CYCLES = 50_000_000,
  parameter int WDOG_LONG   = 350_000_000,
  parameter int WDOG_MID    = 150_000_000,
  parameter int WDOG_SHORT  = 50_000_000
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       supplyLow,
  input  logic       csN,
  input  logic [1:0] timeoutSel,
  output logic       resetHigh,
  output logic       resetLow
);
  supStrobe_t strobe;
  logic stabDone;
  logic wdExpire;
  logic resetActive;

  sup_datapath #(
    .STAB_CYCLES(STAB_CYCLES),
    .WDOG_LONG  (WDOG_LONG),
    .WDOG_MID   (WDOG_MID),
    .WDOG_SHORT (WDOG_SHORT),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk       (clk),
    .porN      (porN),
    .csN       (csN),
    .timeoutSel(timeoutSel),
    .strobe    (strobe),
    .stabDone  (stabDone),
    .wdExpire  (wdExpire)
  );

  sup_control u_ctrl (
    .clk        (clk),
    .porN       (porN),
    .supplyLow  (supplyLow),
    .stabDone   (stabDone),
    .wdExpire   (wdExpire),
    .strobe     (strobe),
    .resetActive(resetActive)
  );

  assign resetHigh = resetActive;
  assign resetLow  = ~resetActive;
endmodule

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
  localparam int S  = 12;
  localparam int LL = 40;
  localparam int LM = 25;
  localparam int LS = 10;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic supplyLow = 1'b1;
  logic csN = 1'b1;
  logic [1:0] timeoutSel = 2'b01;
  logic resetHigh, resetLow;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  rst_supervisor #(.STAB_CYCLES(S), .WDOG_LONG(LL), .WDOG_MID(LM), .WDOG_SHORT(LS)) u0 (
    .clk(clk), .porN(porN), .supplyLow(supplyLow), .csN(csN),
    .timeoutSel(timeoutSel), .resetHigh(resetHigh), .resetLow(resetLow)
  );

  // behavioural reference: 0 holding, 1 stabilising, 2 running
  int mMode = 0;
  int mStab = 0;
  int mWd = 0;
  int mSel = 3;
  bit csHist[$] = '{1'b1, 1'b1, 1'b1};

  function automatic int limitOf(int sel);
    case (sel)
      0: return LL;
      1: return LM;
      2: return LS;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!porN) begin
      mMode = 0; mStab = 0; mWd = 0; mSel = 3;
      csHist = '{1'b1, 1'b1, 1'b1};
    end else begin
      bit kick;
      bit expired;
      int oldMode;
      kick = csHist[2] && !csHist[1];
      expired = (mSel != 3) && (mWd == limitOf(mSel));
      oldMode = mMode;
      if (oldMode == 2) begin
        if (kick) begin mWd = 0; mSel = timeoutSel; end
        else if (mSel != 3 && mWd != limitOf(mSel)) mWd++;
      end
      case (oldMode)
        0: begin mStab = 0; if (!supplyLow) mMode = 1; end
        1: begin
          if (supplyLow) begin mMode = 0; mStab = 0; end
          else if (mStab == S - 1) begin mMode = 2; mWd = 0; mSel = timeoutSel; end
          else mStab++;
        end
        default: begin
          if (supplyLow) begin mMode = 0; mStab = 0; end
          else if (expired) begin mMode = 1; mStab = 0; end
        end
      endcase
      csHist = '{csN, csHist[0], csHist[1]};
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check(resetLow === ~resetHigh, "R7", int'(resetLow), int'(~resetHigh));
      check(resetHigh === (mMode != 2), curReq, int'(resetHigh), int'(mMode != 2));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 20000);
      finish();
    end
  end

  initial begin
    // R1: power-on hold, then supply still low after release
    idle(6);
    check(resetHigh === 1'b1 && resetLow === 1'b0, "R1", int'(resetHigh), 1);
    porN = 1'b1;
    idle(5);
    // R3: stabilisation interval after supply valid
    curReq = "R3";
    supplyLow = 1'b0;
    idle(S + 4);
    // R5: regular kicks keep reset released
    curReq = "R5";
    repeat (6) begin csN = 1'b0; idle(8); csN = 1'b1; idle(8); end
    // R4: stuck high trips the watchdog
    curReq = "R4";
    idle(32);
    // R8: hold after the trip and count restart
    curReq = "R8";
    idle(S + 30);
    // R10: stuck low also trips
    curReq = "R10";
    csN = 1'b0;
    idle(4);
    csN = 1'b1;
    idle(2);
    csN = 1'b0;
    idle(60);
    // R9: selection change mid-count is deferred
    curReq = "R9";
    csN = 1'b1;
    idle(3);
    timeoutSel = 2'b00;
    csN = 1'b0;
    idle(4);
    timeoutSel = 2'b10;
    idle(30);
    csN = 1'b1;
    idle(4);
    csN = 1'b0;
    idle(S + 30);
    // R6: disabled code
    curReq = "R6";
    timeoutSel = 2'b11;
    csN = 1'b1;
    idle(4);
    csN = 1'b0;
    idle(120);
    // R2: supply drop while running, glitch during stabilisation
    curReq = "R2";
    supplyLow = 1'b1;
    idle(5);
    supplyLow = 1'b0;
    idle(5);
    supplyLow = 1'b1;
    idle(2);
    curReq = "R3";
    supplyLow = 1'b0;
    idle(S + 10);
    finish();
  end
endmodule